// File: doc/BRIEF.md
# Bulk Flash Erase Sequencer

This block sits on the host side of a word-wide flash array and carries out a complete bulk erase with a pulse-then-verify loop. After a start request it first asks an external word-programming engine to bring every word to 0000h, so that all cells begin the erase from the same charge state. It then issues erase pulses and checks the words one by one in ascending address order. Each check sets up verify mode for the word, waits for the margin voltage to settle and reads the word back.

A word that reads FFFFh lets the sequencer move on to the next address. A word that reads any other value costs one more erase pulse, and verification picks up again at that same word rather than at address 0. The run stops with a pass once the top word verifies, or with a fail once the pulse budget is spent. In either case the array is left in read mode. Both wait intervals and the pulse budget are parameters counted in clock cycles and pulses. The final pulse count and the last word that failed verification are available at the ports.

Top module: `esq_erase_seq`

## Requirements
- R1: On start_i while idle, pgm_req_o rises and stays high until pgm_done_i is seen. No bus cycle is issued while pgm_req_o is high, and pgm_req_o is low in the cycle after pgm_done_i.
- R2: If pgm_done_i arrives with pgm_ok_i low, no erase command is issued. The only bus cycle is a write of 0000h to address 0, after which done_o and fail_o are set and pulse_cnt_o reads 1.
- R3: An erase pulse is two consecutive bus writes of 0020h to address 0, followed by exactly ERASE_CLKS idle cycles before the next bus request.
- R4: Verifying word A is a write of 00A0h to address A, then exactly VERIFY_CLKS idle cycles, then a bus read of address A. The word passes only if the read data equals FFFFh.
- R5: Verification starts at address 0 after the first pulse and advances by one on each pass. When word WORDS-1 passes, a write of 0000h to address 0 follows, and then done_o and pass_o are set.
- R6: A failing word increments the pulse counter by one and triggers a new erase pulse. Verification then resumes at that same address, which fail_addr_o holds from then on.
- R7: A word that fails while the pulse counter equals MAX_PULSES ends the run. A write of 0000h to address 0 follows, then done_o and fail_o are set, and pulse_cnt_o equals MAX_PULSES.
- R8: After reset, done_o, pass_o, fail_o, pgm_req_o, bus_req_o, pulse_cnt_o and fail_addr_o are all 0.
- R9: While bus_req_o is high and bus_ack_i is low, bus_we_o, bus_addr_o and bus_wdata_o hold their values.
- R10: start_i is ignored while a run is in progress: the bus cycle sequence and the result are unchanged.
- R11: done_o, pass_o and fail_o hold until the next start_i, which clears them. A start also resets pulse_cnt_o to 1 and fail_addr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bulk erase (taken only when idle) |
| done_o | output | 1 | Run finished; held until next start |
| pass_o | output | 1 | Every word verified erased |
| fail_o | output | 1 | Preprogram failed or pulse budget exhausted |
| pulse_cnt_o | output | PCNT_W | Erase pulses issued in this run |
| fail_addr_o | output | ADDR_W | Most recent word that failed verification |
| pgm_req_o | output | 1 | Request to the engine that programs all words to 0000h |
| pgm_done_i | input | 1 | One-cycle completion strobe from the programming engine |
| pgm_ok_i | input | 1 | Programming outcome, valid with pgm_done_i |
| bus_req_o | output | 1 | Bus cycle request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Word address |
| bus_wdata_o | output | 16 | Command word for writes |
| bus_rdata_i | input | 16 | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Bus cycle completes at this clock edge |

## Verification
The bench builds the block with WORDS=8, ERASE_CLKS=12, VERIFY_CLKS=3 and MAX_PULSES=5. With these values the whole address range, several extra pulses and the pulse limit can all be reached in a few hundred cycles. A flash model in the bench gives each word the number of pulses it needs before it reads FFFFh. This makes it possible to produce words that fail in the middle of the array, a word that needs exactly the last allowed pulse, and a word that never erases. The scoreboard compares every bus cycle, and the idle gap before it, with a sequence computed from the requirements.

// File: rtl/esq_pkg.sv
package esq_pkg;
  localparam int DATA_W = 16;

  localparam logic [DATA_W-1:0] CMD_READ  = 16'h0000;
  localparam logic [DATA_W-1:0] CMD_ERASE = 16'h0020;
  localparam logic [DATA_W-1:0] CMD_EVFY  = 16'h00A0;
  localparam logic [DATA_W-1:0] ERASED_W  = 16'hFFFF;

  typedef enum logic [3:0] {
    S_IDLE, S_PREPGM, S_SETUP, S_ERASE, S_EWAIT,
    S_VCMD, S_VWAIT, S_VREAD, S_EXIT
  } esq_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WR_ERASE, OP_WR_EVFY, OP_RD, OP_WR_READ
  } esq_op_e;
endpackage

// File: rtl/esq_timer.sv
module esq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + TW'(1);
    else            cnt_q <= '0;
  end

  assign done_o = run_i && (cnt_q == len_i - TW'(1));
endmodule

// File: rtl/esq_track.sv
module esq_track #(
  parameter int WORDS      = 8,
  parameter int MAX_PULSES = 5,
  parameter int ADDR_W     = 3,
  parameter int PCNT_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              addr_inc_i,
  input  logic              pulse_inc_i,
  input  logic              note_fail_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PCNT_W-1:0] pulse_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              last_o,
  output logic              limit_o
);
  logic [ADDR_W-1:0] addr_q, fail_q;
  logic [PCNT_W-1:0] pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pulse_q <= '0;
      fail_q  <= '0;
    end else if (clr_i) begin
      addr_q  <= '0;
      pulse_q <= PCNT_W'(1);
      fail_q  <= '0;
    end else begin
      if (addr_inc_i)  addr_q  <= addr_q + ADDR_W'(1);
      if (pulse_inc_i) pulse_q <= pulse_q + PCNT_W'(1);
      if (note_fail_i) fail_q  <= addr_q;
    end
  end

  assign addr_o      = addr_q;
  assign pulse_o     = pulse_q;
  assign fail_addr_o = fail_q;
  assign last_o      = (addr_q == ADDR_W'(WORDS - 1));
  assign limit_o     = (pulse_q == PCNT_W'(MAX_PULSES));

  assert_pulse_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o <= PCNT_W'(MAX_PULSES));

  assert_pulse_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != $past(pulse_o)) |->
      (pulse_o == $past(pulse_o) + PCNT_W'(1) || pulse_o == PCNT_W'(1)));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o != $past(addr_o)) |->
      (addr_o == $past(addr_o) + ADDR_W'(1) || addr_o == '0));
endmodule

// File: rtl/esq_bus_map.sv
module esq_bus_map
  import esq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  esq_op_e             op_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                req_o,
  output logic                we_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   wdata_o
);
  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b1;
    addr_o  = '0;
    wdata_o = CMD_READ;
    unique case (op_i)
      OP_WR_ERASE: wdata_o = CMD_ERASE;
      OP_WR_EVFY: begin
        wdata_o = CMD_EVFY;
        addr_o  = addr_i;
      end
      OP_RD: begin
        we_o   = 1'b0;
        addr_o = addr_i;
      end
      OP_WR_READ: wdata_o = CMD_READ;
      default: begin
        req_o = 1'b0;
        we_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/esq_erase_seq.sv
module esq_erase_seq
  import esq_pkg::*;
#(
  parameter int WORDS       = 65536,
  parameter int ERASE_CLKS  = 500000,
  parameter int VERIFY_CLKS = 300,
  parameter int MAX_PULSES  = 1000,
  parameter int ADDR_W      = (WORDS > 1) ? $clog2(WORDS) : 1,
  parameter int PCNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [PCNT_W-1:0] pulse_cnt_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              pgm_req_o,
  input  logic              pgm_done_i,
  input  logic              pgm_ok_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_ack_i
);
  localparam int WMAX = (ERASE_CLKS > VERIFY_CLKS) ? ERASE_CLKS : VERIFY_CLKS;
  localparam int TW   = $clog2(WMAX + 1);

  esq_state_e state_q, state_d;
  esq_op_e    op;
  logic done_q, pass_q, fail_q, ok_q, ok_d, set_ok, finish;
  logic clr, addr_inc, pulse_inc, note_fail, last, limit;
  logic tmr_run, tmr_done, ack;
  logic [TW-1:0]     tmr_len;
  logic [ADDR_W-1:0] addr;

  esq_track #(
    .WORDS(WORDS), .MAX_PULSES(MAX_PULSES), .ADDR_W(ADDR_W), .PCNT_W(PCNT_W)
  ) i_track (
    .clk_i, .rst_ni, .clr_i(clr), .addr_inc_i(addr_inc), .pulse_inc_i(pulse_inc),
    .note_fail_i(note_fail), .addr_o(addr), .pulse_o(pulse_cnt_o),
    .fail_addr_o(fail_addr_o), .last_o(last), .limit_o(limit)
  );

  esq_timer #(.TW(TW)) i_timer (
    .clk_i, .rst_ni, .run_i(tmr_run), .len_i(tmr_len), .done_o(tmr_done)
  );

  esq_bus_map #(.ADDR_W(ADDR_W)) i_map (
    .op_i(op), .addr_i(addr), .req_o(bus_req_o), .we_o(bus_we_o),
    .addr_o(bus_addr_o), .wdata_o(bus_wdata_o)
  );

  assign ack       = bus_req_o && bus_ack_i;
  assign tmr_run   = (state_q == S_EWAIT) || (state_q == S_VWAIT);
  assign tmr_len   = (state_q == S_EWAIT) ? TW'(ERASE_CLKS) : TW'(VERIFY_CLKS);
  assign pgm_req_o = (state_q == S_PREPGM);

  always_comb begin
    unique case (state_q)
      S_SETUP, S_ERASE: op = OP_WR_ERASE;
      S_VCMD:           op = OP_WR_EVFY;
      S_VREAD:          op = OP_RD;
      S_EXIT:           op = OP_WR_READ;
      default:          op = OP_NONE;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    clr       = 1'b0;
    addr_inc  = 1'b0;
    pulse_inc = 1'b0;
    note_fail = 1'b0;
    set_ok    = 1'b0;
    ok_d      = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        clr     = 1'b1;
        state_d = S_PREPGM;
      end
      S_PREPGM: if (pgm_done_i) begin
        if (pgm_ok_i) state_d = S_SETUP;
        else begin
          set_ok  = 1'b1;
          state_d = S_EXIT;
        end
      end
      S_SETUP: if (ack) state_d = S_ERASE;
      S_ERASE: if (ack) state_d = S_EWAIT;
      S_EWAIT: if (tmr_done) state_d = S_VCMD;
      S_VCMD:  if (ack) state_d = S_VWAIT;
      S_VWAIT: if (tmr_done) state_d = S_VREAD;
      S_VREAD: if (ack) begin
        if (bus_rdata_i == ERASED_W) begin
          if (last) begin
            set_ok  = 1'b1;
            ok_d    = 1'b1;
            state_d = S_EXIT;
          end else begin
            addr_inc = 1'b1;
            state_d  = S_VCMD;
          end
        end else begin
          note_fail = 1'b1;
          if (limit) begin
            set_ok  = 1'b1;
            state_d = S_EXIT;
          end else begin
            pulse_inc = 1'b1;
            state_d   = S_SETUP;
          end
        end
      end
      S_EXIT: if (ack) begin
        finish  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_ok) ok_q <= ok_d;
      if (clr) begin
        done_q <= 1'b0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (finish) begin
        done_q <= 1'b1;
        pass_q <= ok_q;
        fail_q <= !ok_q;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;

  assert_quiet_prepgm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_o |-> !bus_req_o);

  assert_bus_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o)));

  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  assert_done_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o)));

  assert_exit_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_ack_i && bus_we_o && bus_wdata_o == CMD_READ));
endmodule

// File: tb/test_esq_erase_seq.sv
module test_esq_erase_seq;
  localparam int WORDS = 8;
  localparam int ECLK  = 12;
  localparam int VCLK  = 3;
  localparam int MAXP  = 5;
  localparam int AW    = 3;
  localparam int PW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, fail, pgm_req, bus_req, bus_we;
  logic pgm_done = 1'b0, pgm_ok = 1'b0, bus_ack = 1'b0;
  logic [PW-1:0] pulse_cnt;
  logic [AW-1:0] fail_addr, bus_addr;
  logic [15:0] bus_wdata, bus_rdata = 16'h0;

  always #10 clk = ~clk;

  esq_erase_seq #(
    .WORDS(WORDS), .ERASE_CLKS(ECLK), .VERIFY_CLKS(VCLK), .MAX_PULSES(MAXP)
  ) i_esq_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .pass_o(pass),
    .fail_o(fail), .pulse_cnt_o(pulse_cnt), .fail_addr_o(fail_addr),
    .pgm_req_o(pgm_req), .pgm_done_i(pgm_done), .pgm_ok_i(pgm_ok),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  typedef struct {
    logic        we;
    int          addr;
    logic [15:0] data;
    int          gap;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  int need[WORDS];
  int erase_writes = 0;
  int gap_cnt = 0;
  bit cfg_ok = 1'b1;
  bit finished = 1'b0;

  task automatic chk(bit cond, string req, string what, int act, int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(logic we, int addr, logic [15:0] data, int gap, string tag);
    item_t it;
    it.we = we; it.addr = addr; it.data = data; it.gap = gap; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Expected bus sequence and result, derived from the requirements
  task automatic build(bit ok, output bit e_pass, output int e_pulse, output int e_faddr);
    int p, a, g;
    exp_q.delete();
    e_faddr = 0; e_pulse = 1; e_pass = 1'b0;
    if (!ok) begin
      push(1'b1, 0, 16'h0000, -1, "R2");
      return;
    end
    p = 1; a = 0;
    push(1'b1, 0, 16'h0020, -1, "R3");
    push(1'b1, 0, 16'h0020, 0, "R3");
    g = ECLK;
    forever begin
      push(1'b1, a, 16'h00A0, g, "R4");
      push(1'b0, a, 16'h0000, VCLK, "R4");
      if (p >= need[a]) begin
        if (a == WORDS - 1) begin
          push(1'b1, 0, 16'h0000, 0, "R5");
          e_pass = 1'b1;
          break;
        end
        a++; g = 0;
      end else begin
        e_faddr = a;
        if (p == MAXP) begin
          push(1'b1, 0, 16'h0000, 0, "R7");
          break;
        end
        p++;
        push(1'b1, 0, 16'h0020, 0, "R6");
        push(1'b1, 0, 16'h0020, 0, "R6");
        g = ECLK;
      end
    end
    e_pulse = p;
  endtask

  // Bus responder, flash model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!bus_req) gap_cnt++;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected bus cycle addr", int'(bus_addr), -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(bus_we == it.we, it.tag, "bus direction", int'(bus_we), int'(it.we));
          chk(int'(bus_addr) == it.addr, it.tag, "bus address", int'(bus_addr), it.addr);
          if (it.we) chk(bus_wdata == it.data, it.tag, "command word", int'(bus_wdata), int'(it.data));
          if (it.gap >= 0) chk(gap_cnt == it.gap, it.tag, "idle cycles before cycle", gap_cnt, it.gap);
        end
        if (bus_we && bus_wdata == 16'h0020) erase_writes++;
        bus_rdata = ((erase_writes / 2) >= need[bus_addr]) ? 16'hFFFF : 16'h0000;
        bus_ack = 1'b1;
        gap_cnt = 0;
      end
    end
  end

  // Preprogram engine model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (pgm_req && !pgm_done) begin
        bit held;
        held = 1'b1;
        repeat (4) begin
          @(negedge clk); #1;
          if (!pgm_req || bus_req) held = 1'b0;
        end
        chk(held, "R1", "request held, bus quiet", int'(held), 1);
        pgm_ok = cfg_ok;
        pgm_done = 1'b1;
        @(negedge clk); #1;
        pgm_done = 1'b0;
        chk(!pgm_req, "R1", "request dropped after done", int'(pgm_req), 0);
      end
    end
  end

  task automatic run_case(string name, bit ok, bit poke);
    bit e_pass;
    int e_pulse, e_faddr, n;
    cfg_ok = ok;
    erase_writes = 0;
    build(ok, e_pass, e_pulse, e_faddr);
    @(negedge clk); #1; start = 1'b1;
    @(negedge clk); #1; start = 1'b0;
    chk(!done && !pass && !fail, "R11", {name, " flags cleared by start"}, int'({done, pass, fail}), 0);
    chk(int'(pulse_cnt) == 1 && fail_addr == '0, "R11", {name, " counters cleared by start"},
        int'(pulse_cnt), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      #1; start = 1'b1;
      @(negedge clk); #1; start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); #1; n++;
    end
    chk(done, "R5", {name, " run completes"}, int'(done), 1);
    chk(pass == e_pass, e_pass ? "R5" : "R7", {name, " pass flag"}, int'(pass), int'(e_pass));
    chk(fail == !e_pass, ok ? "R7" : "R2", {name, " fail flag"}, int'(fail), int'(!e_pass));
    chk(int'(pulse_cnt) == e_pulse, "R6", {name, " pulse count"}, int'(pulse_cnt), e_pulse);
    chk(int'(fail_addr) == e_faddr, "R6", {name, " last failing word"}, int'(fail_addr), e_faddr);
    chk(exp_q.size() == 0, "R10", {name, " all expected cycles seen"}, exp_q.size(), 0);
    repeat (6) @(negedge clk);
    #1;
    chk(done && pass == e_pass && !bus_req, "R11", {name, " result held"},
        int'({done, pass}), int'({1'b1, e_pass}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (need[i]) need[i] = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !pass && !fail && !pgm_req && !bus_req, "R8", "reset flags",
        int'({done, pass, fail, pgm_req, bus_req}), 0);
    chk(pulse_cnt == '0 && fail_addr == '0, "R8", "reset counters", int'(pulse_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // one pulse erases all
    need = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_case("single_pulse", 1'b1, 1'b0);

    // scattered failures, resume at failing word, stray start mid-run
    need = '{1, 1, 3, 1, 2, 3, 1, 4};
    run_case("scattered_R6", 1'b1, 1'b1);

    // word 0 needs exactly the last allowed pulse
    need = '{5, 1, 1, 1, 1, 1, 1, 1};
    run_case("limit_edge", 1'b1, 1'b0);

    // word 5 never erases within the budget
    need = '{1, 2, 1, 1, 1, 9, 1, 1};
    run_case("budget_R7", 1'b1, 1'b0);

    // preprogram engine reports failure
    need = '{1, 1, 1, 1, 1, 1, 1, 1};
    run_case("prepgm_R2", 1'b0, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule